// File: doc/BRIEF.md
# UART Automatic Modem Handshake Controller

This block adds automatic hardware handshaking to one UART channel. On the receive side it drives a request line from the receive FIFO fill level, with hysteresis between a halt threshold and a lower resume threshold. On the transmit side it watches a remote-ready input and withholds a transmit permit from the transmitter. The permit is only withdrawn at a character boundary. It also raises one flow-control interrupt status bit.

A single selector chooses the line pair that the mechanism uses. With the selector at 0 the block uses request-to-send and clear-to-send. With the selector at 1 it uses data-terminal-ready and data-set-ready. The line that is not selected follows its manual control bit. Automatic output control is armed only when two things hold: software has enabled the feature, and software has set the manual level of the selected output active. Interrupts pass through a master gate and then through an individual enable for each source.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, `tx_permit` is 1 and `flow_irq` is 0. With both manual bits at 0, `rts_n` and `dtr_n` are both 1 (inactive).
- R2: While automatic output control is disabled, `rts_n` equals the inverse of `man_rts` and `dtr_n` equals the inverse of `man_dtr`.
- R3: Enabling automatic output control has no effect on the selected output while its manual bit is 0. The output stays inactive (1) whatever the FIFO level is.
- R4: Once armed, the selected output goes inactive (1) one cycle after `rx_level >= halt_lvl`. It goes active (0) one cycle after `rx_level <= resume_lvl`. At levels in between it keeps its previous value.
- R5: `pair_sel` = 0 applies automatic output control to `rts_n`. `pair_sel` = 1 applies it to `dtr_n`. While `pair_sel` = 1, `rts_n` follows `man_rts`.
- R6: With transmit gating enabled and the transmitter idle (`tx_busy` = 0), a low-to-high change on the monitored input clears `tx_permit` three clock edges after the change. Two of those edges are synchronizer stages and one is the permit register.
- R7: While a character is in progress (`tx_busy` = 1), `tx_permit` stays 1 until `tx_char_done` is pulsed. It goes to 0 on the edge that samples that pulse.
- R8: When the monitored input returns low, `tx_permit` returns to 1 on the third clock edge.
- R9: With transmit gating disabled, `tx_permit` stays 1 whatever the monitored input does.
- R10: With `irq_master` and `irq_in_en` set, a low-to-high change on the monitored input sets `flow_irq` three edges later. A one-cycle `msr_rd` pulse clears it on the next edge.
- R11: With `irq_master` at 0, `flow_irq` never becomes set, even when the individual enables are 1.
- R12: With `irq_master` and `irq_out_en` set, the armed automatic output going inactive sets `flow_irq` on the same edge.
- R13: `pair_sel` = 0 monitors `cts_n` and `pair_sel` = 1 monitors `dsr_n`. The input that is not monitored has no effect on `tx_permit` or `flow_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_in_en | input | 1 | Enable automatic transmit gating from the monitored input |
| auto_out_en | input | 1 | Enable automatic output control from the FIFO level |
| irq_master | input | 1 | Master gate for flow-control interrupts |
| irq_in_en | input | 1 | Interrupt enable for the monitored-input pause request |
| irq_out_en | input | 1 | Interrupt enable for the automatic output going inactive |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| man_rts | input | 1 | Manual request-to-send level, 1 = active |
| man_dtr | input | 1 | Manual data-terminal-ready level, 1 = active |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_lvl | input | LVL_W | Level at or above which the output is dropped |
| resume_lvl | input | LVL_W | Level at or below which the output is restored |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| tx_busy | input | 1 | Transmitter has a character in progress |
| tx_char_done | input | 1 | One-cycle strobe after the stop bit has gone out |
| tx_permit | output | 1 | Transmitter may start a new character |
| msr_rd | input | 1 | Modem-status read strobe, clears the status |
| flow_irq | output | 1 | Flow-control interrupt status |

## Verification
Some properties are checked on every cycle. These are: the permit holding through a character in progress, the permit staying high while gating is off, manual pass-through of the outputs, the unselected request output following its manual bit, and the interrupt staying clear without the master gate. Other behaviours only the bench scenarios can show. These are: the hysteresis band walked level by level, the arming sequence, the exact three-edge latency through the synchronizer, the character-boundary pause, and the choice of monitored input by the pair selector.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  input  logic [WIDTH-1:0] reset_val,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] d;
      if (s == 0) begin : g_first
        assign d = async_i;
      end else begin : g_rest
        assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= reset_val;
        else        stage_q[s] <= d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_level_ctl.sv
module hs_level_ctl #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             man_sel,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             armed,
  output logic             auto_act,
  output logic             drop_evt
);
  logic armed_q, armed_d;
  logic hold_q, hold_d;
  logic upd_en;

  always_comb begin
    armed_d = auto_en & (armed_q | man_sel);
  end

  always_comb begin
    hold_d = hold_q;
    if (!armed_q) begin
      hold_d = 1'b0;
    end else if (level >= halt_lvl) begin
      hold_d = 1'b1;
    end else if (level <= resume_lvl) begin
      hold_d = 1'b0;
    end
  end

  assign upd_en = (hold_d != hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (upd_en) hold_q <= hold_d;
  end

  assign armed    = armed_q;
  assign auto_act = armed_q & ~hold_q;
  assign drop_evt = armed_q & hold_d & ~hold_q;
endmodule

// File: rtl/hs_tx_gate.sv
module hs_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_req,
  input  logic tx_busy,
  input  logic tx_char_done,
  output logic tx_permit
);
  logic permit_q, permit_d;

  always_comb begin
    if (!pause_req) begin
      permit_d = 1'b1;
    end else if (permit_q && tx_busy && !tx_char_done) begin
      permit_d = 1'b1;
    end else begin
      permit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) permit_q <= 1'b1;
    else        permit_q <= permit_d;
  end

  assign tx_permit = permit_q;
endmodule

// File: rtl/hs_irq.sv
module hs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic in_en,
  input  logic out_en,
  input  logic in_evt,
  input  logic out_evt,
  input  logic clr,
  output logic status
);
  logic stat_q, stat_d;
  logic set_evt;

  always_comb begin
    set_evt = master & ((in_en & in_evt) | (out_en & out_evt));
    stat_d  = stat_q;
    if (set_evt)  stat_d = 1'b1;
    else if (clr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import flow_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_in_en,
  input  logic             auto_out_en,
  input  logic             irq_master,
  input  logic             irq_in_en,
  input  logic             irq_out_en,
  input  logic             pair_sel,
  input  logic             man_rts,
  input  logic             man_dtr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  input  logic             tx_busy,
  input  logic             tx_char_done,
  output logic             tx_permit,
  input  logic             msr_rd,
  output logic             flow_irq
);
  localparam int unsigned NLINES = 2;

  pair_e             pair;
  logic [NLINES-1:0] pins_sync;
  logic              mon_q;
  logic              mon_now;
  logic              mon_rise;
  logic              pause_req;
  logic              man_sel;
  logic              armed;
  logic              auto_act;
  logic              drop_evt;
  logic              rts_act;
  logic              dtr_act;

  assign pair = pair_e'(pair_sel);

  hs_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_i   ({dsr_n, cts_n}),
    .reset_val ('0),
    .sync_o    (pins_sync)
  );

  assign mon_now = (pair == PAIR_DTR_DSR) ? pins_sync[1] : pins_sync[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mon_q <= 1'b0;
    else        mon_q <= mon_now;
  end

  assign mon_rise  = mon_now & ~mon_q;
  assign pause_req = auto_in_en & mon_now;
  assign man_sel   = (pair == PAIR_DTR_DSR) ? man_dtr : man_rts;

  hs_level_ctl #(
    .LVL_W (LVL_W)
  ) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_out_en),
    .man_sel    (man_sel),
    .level      (rx_level),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl),
    .armed      (armed),
    .auto_act   (auto_act),
    .drop_evt   (drop_evt)
  );

  always_comb begin
    rts_act = man_rts;
    dtr_act = man_dtr;
    if (armed) begin
      if (pair == PAIR_DTR_DSR) dtr_act = auto_act;
      else                      rts_act = auto_act;
    end
  end

  assign rts_n = ~rts_act;
  assign dtr_n = ~dtr_act;

  hs_tx_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_req    (pause_req),
    .tx_busy      (tx_busy),
    .tx_char_done (tx_char_done),
    .tx_permit    (tx_permit)
  );

  hs_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (irq_master),
    .in_en   (irq_in_en),
    .out_en  (irq_out_en),
    .in_evt  (mon_rise),
    .out_evt (drop_evt),
    .clr     (msr_rd),
    .status  (flow_irq)
  );
endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_in_en,
  input logic auto_out_en,
  input logic irq_master,
  input logic pair_sel,
  input logic man_rts,
  input logic man_dtr,
  input logic tx_busy,
  input logic tx_char_done,
  input logic msr_rd,
  input logic rts_n,
  input logic dtr_n,
  input logic tx_permit,
  input logic flow_irq
);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && tx_busy && !tx_char_done) |=> tx_permit);

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_in_en |=> tx_permit);

  // R2
  manual_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_out_en && !$past(auto_out_en)) |-> (rts_n == !man_rts));

  // R2
  manual_dtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_out_en && !$past(auto_out_en)) |-> (dtr_n == !man_dtr));

  // R5
  unsel_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_sel |-> (rts_n == !man_rts));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_master && !flow_irq) |=> !flow_irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !irq_master) |=> !flow_irq);
endmodule

bind uart_autoflow uart_autoflow_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .auto_in_en   (auto_in_en),
  .auto_out_en  (auto_out_en),
  .irq_master   (irq_master),
  .pair_sel     (pair_sel),
  .man_rts      (man_rts),
  .man_dtr      (man_dtr),
  .tx_busy      (tx_busy),
  .tx_char_done (tx_char_done),
  .msr_rd       (msr_rd),
  .rts_n        (rts_n),
  .dtr_n        (dtr_n),
  .tx_permit    (tx_permit),
  .flow_irq     (flow_irq)
);

// File: tb/test_uart_autoflow.sv
`timescale 1ns/1ps
module test_uart_autoflow;
  localparam int unsigned LVL_W = 5;
  localparam int unsigned NVEC  = 10;
  // each entry: {expected rts_n, rx_level}; halt 12, resume 4
  localparam logic [LVL_W:0] VEC [NVEC] = '{
    {1'b0, 5'd0},  {1'b0, 5'd8},  {1'b1, 5'd12}, {1'b1, 5'd10},
    {1'b1, 5'd5},  {1'b0, 5'd4},  {1'b0, 5'd9},  {1'b1, 5'd15},
    {1'b1, 5'd11}, {1'b0, 5'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic auto_in_en, auto_out_en, irq_master, irq_in_en, irq_out_en;
  logic pair_sel, man_rts, man_dtr;
  logic [LVL_W-1:0] rx_level, halt_lvl, resume_lvl;
  logic cts_n, dsr_n, rts_n, dtr_n;
  logic tx_busy, tx_char_done, tx_permit, msr_rd, flow_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_autoflow #(.LVL_W(LVL_W)) i_uart_autoflow (
    .clk(clk), .rst_n(rst_n),
    .auto_in_en(auto_in_en), .auto_out_en(auto_out_en),
    .irq_master(irq_master), .irq_in_en(irq_in_en), .irq_out_en(irq_out_en),
    .pair_sel(pair_sel), .man_rts(man_rts), .man_dtr(man_dtr),
    .rx_level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n),
    .tx_busy(tx_busy), .tx_char_done(tx_char_done), .tx_permit(tx_permit),
    .msr_rd(msr_rd), .flow_irq(flow_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    auto_in_en = 0; auto_out_en = 0; irq_master = 0; irq_in_en = 0; irq_out_en = 0;
    pair_sel = 0; man_rts = 0; man_dtr = 0;
    rx_level = '0; halt_lvl = 5'd12; resume_lvl = 5'd4;
    cts_n = 0; dsr_n = 0; tx_busy = 0; tx_char_done = 0; msr_rd = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 dtr_n", dtr_n, 1'b1);
    chk("R1 tx_permit", tx_permit, 1'b1);
    chk("R1 flow_irq", flow_irq, 1'b0);

    man_rts = 1; man_dtr = 1; tick(1);
    chk("R2 rts_n", rts_n, 1'b0);
    chk("R2 dtr_n", dtr_n, 1'b0);
    man_rts = 0; man_dtr = 0; tick(1);

    auto_out_en = 1; tick(3);
    chk("R3 unarmed", rts_n, 1'b1);
    man_rts = 1; tick(2);
    chk("R3 armed", rts_n, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      rx_level = VEC[i][LVL_W-1:0];
      tick(1);
      chk("R4 hysteresis", rts_n, VEC[i][LVL_W]);
    end

    irq_master = 1; irq_out_en = 1;
    rx_level = 5'd14; tick(1);
    chk("R12 irq", flow_irq, 1'b1);
    chk("R12 rts_n", rts_n, 1'b1);
    msr_rd = 1; tick(1); msr_rd = 0;
    chk("R10 clear", flow_irq, 1'b0);
    rx_level = 5'd0; tick(1);
    chk("R4 restore", rts_n, 1'b0);
    irq_out_en = 0; irq_master = 0;

    pair_sel = 1; man_dtr = 1; rx_level = 5'd14; tick(2);
    chk("R5 dtr auto", dtr_n, 1'b1);
    chk("R5 rts manual", rts_n, 1'b0);
    rx_level = 5'd0; tick(1);
    chk("R5 dtr resume", dtr_n, 1'b0);
    man_rts = 0; tick(1);
    chk("R5 rts follows", rts_n, 1'b1);
    pair_sel = 0; auto_out_en = 0; man_dtr = 0; tick(2);

    cts_n = 1; tick(4);
    chk("R9 ungated", tx_permit, 1'b1);
    cts_n = 0; tick(3);

    auto_in_en = 1; cts_n = 1; tick(2);
    chk("R6 not yet", tx_permit, 1'b1);
    tick(1);
    chk("R6 paused", tx_permit, 1'b0);
    cts_n = 0; tick(2);
    chk("R8 not yet", tx_permit, 1'b0);
    tick(1);
    chk("R8 resumed", tx_permit, 1'b1);

    tx_busy = 1; cts_n = 1; tick(6);
    chk("R7 mid-char", tx_permit, 1'b1);
    tx_char_done = 1; tx_busy = 0; tick(1);
    tx_char_done = 0;
    chk("R7 boundary", tx_permit, 1'b0);
    cts_n = 0; tick(3);
    chk("R8 after char", tx_permit, 1'b1);

    irq_in_en = 1; cts_n = 1; tick(4);
    chk("R11 gated", flow_irq, 1'b0);
    cts_n = 0; tick(3);
    irq_master = 1; cts_n = 1; tick(2);
    chk("R10 not yet", flow_irq, 1'b0);
    tick(1);
    chk("R10 set", flow_irq, 1'b1);
    msr_rd = 1; tick(1); msr_rd = 0;
    chk("R10 read clear", flow_irq, 1'b0);
    cts_n = 0; tick(3);

    pair_sel = 1; cts_n = 1; tick(4);
    chk("R13 cts ignored permit", tx_permit, 1'b1);
    chk("R13 cts ignored irq", flow_irq, 1'b0);
    dsr_n = 1; tick(3);
    chk("R13 dsr pause", tx_permit, 1'b0);
    chk("R13 dsr irq", flow_irq, 1'b1);
    dsr_n = 0; tick(3);
    chk("R13 dsr resume", tx_permit, 1'b1);

    rst_n = 0; tick(1);
    chk("R1 reset irq", flow_irq, 1'b0);
    chk("R1 reset permit", tx_permit, 1'b1);
    rst_n = 1; tick(1);
    finish_run();
  end
endmodule